// File: doc/BRIEF.md
# Shared-Bus FIFO Port Access Controller

This block sits at one data port of a two-FIFO buffer where a single 36-bit bidirectional bus both fills the outbound FIFO and drains the inbound FIFO. Each cycle it decodes the port controls into one of five actions: idle, an outbound FIFO write, an inbound FIFO read, a mailbox write or a mailbox read. The port controls are chip select (active low), the direction select (high for write, low for read), the enable and the mailbox select. The FIFO strobes are qualified by the outbound FIFO's space-available flag and the inbound FIFO's data-available flag. The mailbox strobes need no flag.

The bus output enable follows only chip select and the direction select, so a read cycle drives the bus even while the inbound FIFO is empty. Read data is captured in a port register on the clock edge that carries the read strobe. It appears on the bus from the next cycle on, and it stays there until the next FIFO read. Write data passes straight from the bus to the outbound FIFO. The port never looks at the other port of the buffer.

Top module: `bidir_port_ctrl`

## Requirements
- R1: `bus_oe` is 1 exactly when `cs_n` is 0 and `wr_sel` is 0 (wr_sel 1 = write direction, 0 = read direction); otherwise the bus is released.
- R2: `fifo_wr` is 1 exactly when `cs_n`=0, `wr_sel`=1, `en`=1, `mbx_sel`=0 and `in_ready`=1.
- R3: `fifo_rd` is 1 exactly when `cs_n`=0, `wr_sel`=0, `en`=1, `mbx_sel`=0 and `out_ready`=1.
- R4: `fifo_wdata` always equals `bus_in`, so the outbound FIFO stores the bus value in a cycle where `fifo_wr` is 1.
- R5: With `mbx_sel`=1, both FIFO strobes are 0. `mbx_wr` is 1 when `cs_n`=0, `en`=1 and `wr_sel`=1. `mbx_rd` is 1 when `cs_n`=0, `en`=1 and `wr_sel`=0. Both mailbox strobes ignore the two status flags and are 0 whenever `mbx_sel`=0.
- R6: After a rising edge where `fifo_rd` is 1, `bus_out` equals the `fifo_rdata` value present at that edge.
- R7: After a rising edge where `fifo_rd` is 0, `bus_out` keeps its previous value, including in cycles that drive the bus with an empty inbound FIFO.
- R8: At most one of `fifo_wr`, `fifo_rd`, `mbx_wr` and `mbx_rd` is 1 in any cycle.
- R9: While `rst_n` is 0 and after its release, `bus_out` is all zeros until the first FIFO read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| wr_sel | input | 1 | Direction select: 1 write, 0 read |
| en | input | 1 | Access enable |
| mbx_sel | input | 1 | Selects mailbox instead of FIFO |
| in_ready | input | 1 | Outbound FIFO can accept a word |
| out_ready | input | 1 | Inbound FIFO holds a word |
| bus_in | input | 36 | Bus value seen at the pins |
| fifo_rdata | input | 36 | Head word of the inbound FIFO |
| bus_out | output | 36 | Registered read data for the bus |
| bus_oe | output | 1 | Bus drive enable |
| fifo_wr | output | 1 | Outbound FIFO write strobe |
| fifo_wdata | output | 36 | Outbound FIFO write data |
| fifo_rd | output | 1 | Inbound FIFO read strobe |
| mbx_wr | output | 1 | Mailbox write strobe |
| mbx_rd | output | 1 | Mailbox read strobe |

## Verification
Two functions share a cycle here. The bus drive is decided from chip select and direction alone, while the read-data register changes only on a qualified FIFO read. So the bench sweeps all 64 combinations of the six control and flag inputs, with a fresh data word each time. It then judges, one cycle later, whether `bus_out` took the new word or kept the old one. The same sweep places mailbox select against every flag setting, so that any overlap of a mailbox strobe with a FIFO strobe, or any flag leak into the mailbox path, shows up as a mismatch against the arithmetically predicted strobe set.

// File: rtl/pac_pkg.sv
package pac_pkg;
    localparam int unsigned BUS_W = 36;

    typedef enum logic [2:0] {
        ACT_IDLE    = 3'd0,
        ACT_FIFO_WR = 3'd1,
        ACT_FIFO_RD = 3'd2,
        ACT_MBX_WR  = 3'd3,
        ACT_MBX_RD  = 3'd4
    } port_act_e;

    typedef struct packed {
        logic fifo_wr;
        logic fifo_rd;
        logic mbx_wr;
        logic mbx_rd;
    } strobe_t;
endpackage

// File: rtl/pac_decode.sv
module pac_decode
    import pac_pkg::*;
(
    input  logic      cs_n,
    input  logic      wr_sel,
    input  logic      en,
    input  logic      mbx_sel,
    input  logic      in_ready,
    input  logic      out_ready,
    output port_act_e act,
    output strobe_t   strb,
    output logic      drive
);
    always_comb begin
        act = ACT_IDLE;
        if (!cs_n && en) begin
            if (mbx_sel) begin
                act = wr_sel ? ACT_MBX_WR : ACT_MBX_RD;
            end else if (wr_sel) begin
                if (in_ready) act = ACT_FIFO_WR;
            end else begin
                if (out_ready) act = ACT_FIFO_RD;
            end
        end
    end

    always_comb begin
        strb.fifo_wr = (act == ACT_FIFO_WR);
        strb.fifo_rd = (act == ACT_FIFO_RD);
        strb.mbx_wr  = (act == ACT_MBX_WR);
        strb.mbx_rd  = (act == ACT_MBX_RD);
        drive        = !cs_n && !wr_sel;
    end
endmodule

// File: rtl/pac_rdreg.sv
module pac_rdreg #(
    parameter int unsigned DATA_W = 36
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);
    typedef struct packed {
        logic [DATA_W-1:0] data;
    } rd_state_t;

    rd_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (load) state_d.data = din;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign dout = state_q.data;
endmodule

// File: rtl/bidir_port_ctrl.sv
module bidir_port_ctrl
    import pac_pkg::*;
#(
    parameter int unsigned DATA_W = BUS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              wr_sel,
    input  logic              en,
    input  logic              mbx_sel,
    input  logic              in_ready,
    input  logic              out_ready,
    input  logic [DATA_W-1:0] bus_in,
    input  logic [DATA_W-1:0] fifo_rdata,
    output logic [DATA_W-1:0] bus_out,
    output logic              bus_oe,
    output logic              fifo_wr,
    output logic [DATA_W-1:0] fifo_wdata,
    output logic              fifo_rd,
    output logic              mbx_wr,
    output logic              mbx_rd
);
    port_act_e act;
    strobe_t   strb;
    logic      drive;

    pac_decode i_decode (
        .cs_n      (cs_n),
        .wr_sel    (wr_sel),
        .en        (en),
        .mbx_sel   (mbx_sel),
        .in_ready  (in_ready),
        .out_ready (out_ready),
        .act       (act),
        .strb      (strb),
        .drive     (drive)
    );

    pac_rdreg #(.DATA_W(DATA_W)) i_rdreg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (strb.fifo_rd),
        .din   (fifo_rdata),
        .dout  (bus_out)
    );

    assign bus_oe     = drive;
    assign fifo_wr    = strb.fifo_wr;
    assign fifo_rd    = strb.fifo_rd;
    assign mbx_wr     = strb.mbx_wr;
    assign mbx_rd     = strb.mbx_rd;
    assign fifo_wdata = bus_in;

    logic unused_act;
    assign unused_act = ^act;
endmodule

// File: rtl/pac_chk.sv
module pac_chk #(
    parameter int unsigned DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_ready,
    input logic              out_ready,
    input logic              mbx_sel,
    input logic [DATA_W-1:0] fifo_rdata,
    input logic [DATA_W-1:0] bus_out,
    input logic              fifo_wr,
    input logic              fifo_rd,
    input logic              mbx_wr,
    input logic              mbx_rd
);
    logic past_ok_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok_q <= 1'b0;
        else        past_ok_q <= 1'b1;
    end

    // R2: no write into a FIFO lacking space
    a_r2_wr_needs_space: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_wr |-> in_ready);

    // R3: no read from an empty FIFO
    a_r3_rd_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_rd |-> out_ready);

    // R5: mailbox selection keeps FIFO strobes quiet
    a_r5_mbx_blocks_fifo: assert property (@(posedge clk) disable iff (!rst_n)
        mbx_sel |-> !fifo_wr && !fifo_rd);

    // R6: read word lands on the bus one cycle later
    a_r6_read_lands: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && $past(fifo_rd) |-> bus_out == $past(fifo_rdata));

    // R7: no read, no change
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok_q && !$past(fifo_rd) |-> $stable(bus_out));

    // R8: one strobe at most
    a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({fifo_wr, fifo_rd, mbx_wr, mbx_rd}));
endmodule

bind bidir_port_ctrl pac_chk #(.DATA_W(DATA_W)) i_pac_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_ready   (in_ready),
    .out_ready  (out_ready),
    .mbx_sel    (mbx_sel),
    .fifo_rdata (fifo_rdata),
    .bus_out    (bus_out),
    .fifo_wr    (fifo_wr),
    .fifo_rd    (fifo_rd),
    .mbx_wr     (mbx_wr),
    .mbx_rd     (mbx_rd)
);

// File: tb/test_bidir_port_ctrl.sv
`timescale 1ns/1ps
module test_bidir_port_ctrl;
    localparam int W = 36;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, wr_sel = 1'b0, en = 1'b0, mbx_sel = 1'b0;
    logic in_ready = 1'b0, out_ready = 1'b0;
    logic [W-1:0] bus_in = '0, fifo_rdata = '0;
    logic [W-1:0] bus_out, fifo_wdata;
    logic bus_oe, fifo_wr, fifo_rd, mbx_wr, mbx_rd;

    int n_chk = 0, n_fail = 0;
    logic [W-1:0] exp_bus;
    bit done = 0;

    always #2.5 clk = ~clk;

    bidir_port_ctrl i_bidir_port_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_sel(wr_sel), .en(en),
        .mbx_sel(mbx_sel), .in_ready(in_ready), .out_ready(out_ready),
        .bus_in(bus_in), .fifo_rdata(fifo_rdata), .bus_out(bus_out),
        .bus_oe(bus_oe), .fifo_wr(fifo_wr), .fifo_wdata(fifo_wdata),
        .fifo_rd(fifo_rd), .mbx_wr(mbx_wr), .mbx_rd(mbx_rd)
    );

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    initial begin
        #40000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 chk("R9 reset", bus_out, '0);
        @(negedge clk) rst_n = 1'b1;
        @(posedge clk); #1 chk("R9 after release", bus_out, '0);
        exp_bus = '0;
        for (int pass = 0; pass < 2; pass++) begin
            for (int c = 0; c < 64; c++) begin
                logic e_wr, e_rd, e_mw, e_mr, e_oe;
                @(negedge clk);
                {cs_n, wr_sel, en, mbx_sel, in_ready, out_ready} = 6'(c);
                bus_in     = {4'(c), 32'hA5C3_0000 + 32'(pass*64 + c)};
                fifo_rdata = {4'(~c), 32'h3C00_1000 + 32'(c * 7 + pass)};
                e_oe = !cs_n && !wr_sel;
                e_wr = !cs_n &&  wr_sel && en && !mbx_sel && in_ready;
                e_rd = !cs_n && !wr_sel && en && !mbx_sel && out_ready;
                e_mw = !cs_n &&  wr_sel && en &&  mbx_sel;
                e_mr = !cs_n && !wr_sel && en &&  mbx_sel;
                #1;
                chk("R1 bus_oe", W'(bus_oe), W'(e_oe));
                chk("R2 fifo_wr", W'(fifo_wr), W'(e_wr));
                chk("R3 fifo_rd", W'(fifo_rd), W'(e_rd));
                chk("R4 fifo_wdata", fifo_wdata, bus_in);
                chk("R5 mailbox strobes", W'({mbx_wr, mbx_rd}), W'({e_mw, e_mr}));
                chk("R8 strobe count", W'($countones({fifo_wr, fifo_rd, mbx_wr, mbx_rd})),
                    W'(32'(e_wr) + 32'(e_rd) + 32'(e_mw) + 32'(e_mr)));
                if (e_rd) exp_bus = fifo_rdata;
                @(posedge clk); #1;
                if (e_rd) chk("R6 read data on bus", bus_out, exp_bus);
                else      chk("R7 bus data held", bus_out, exp_bus);
            end
        end
        @(negedge clk) cs_n = 1'b1;
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule